// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a segment register choice and a 16-bit offset into a linear byte address, every cycle, with no pipeline delay. It runs in one of two modes chosen by an input. In the legacy mode, each segment register holds a 16-bit paragraph number. That number is scaled by sixteen and added to the offset, and the sum wraps at 20 bits. In the protected mode, each segment register has a cached descriptor that gives a 24-bit byte base, a 16-bit limit, type bits and a null marker. The base is added to the offset without any scaling.

In protected mode, every access is also checked against the cached descriptor. A check may reject the access because of the offset window, the access kind, or a null selector. The rejection is reported as a cause code in the same cycle as the address. There are four cache entries, one per segment register (code, data, extra, stack). They are written through a load port on a clock edge, and reading them is purely combinational. The block does not fetch descriptors from memory and does not check privilege; it only uses entries that are already loaded.

Top module: `seg_agen`

## Requirements
- R1: With `prot_mode`=0, `lin_addr` equals ((segment value << 4) + offset) modulo 2^20, and `lin_addr[23:20]` is zero.
- R2: With `prot_mode`=0, `fault_cause` is 0. This holds whatever the entry's type, limit or null flag.
- R3: With `prot_mode`=1, `lin_addr` equals (entry base + zero-extended offset) modulo 2^24. The address is driven even when a fault is reported.
- R4: For a protected access to a code entry, or to a data entry with `ld_down`=0, an offset greater than the limit gives `fault_cause`=1. An offset equal to the limit is legal. The grow-down flag is ignored on code entries.
- R5: For a protected access to a data entry loaded with `ld_down`=1, an offset at or below the limit gives `fault_cause`=1. Offsets from limit+1 up to 0xFFFF are legal.
- R6: Access kind is encoded as 0 = read, 1 = write, 2 = fetch, and 3 = read. In protected mode, a write to a code entry gives `fault_cause`=2, and a fetch from a data entry gives `fault_cause`=2.
- R7: On a code entry, `ld_perm` means readable: a read with `ld_perm`=0 gives cause 2, and a fetch is always allowed. On a data entry, `ld_perm` means writable: a write with `ld_perm`=0 gives cause 2, and a read is always allowed.
- R8: A protected access through an entry whose null flag is set gives `fault_cause`=3, whatever the offset and access kind.
- R9: When several causes apply, only one is reported, with this priority: null (3) first, then access (2), then limit (1).
- R10: `fault` is 1 exactly when `fault_cause` is non-zero. The cause encoding is 0 none, 1 limit, 2 access, 3 null.
- R11: A load with `ld_en`=1 writes entry `ld_idx` on the rising clock edge. The new contents take effect on the outputs only after that edge, and the other entries do not change.
- R12: After reset, every entry is null, with base 0, limit 0 and segment value 0. A protected access therefore gives cause 3, and a legacy access gives the offset itself as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cache load |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_mode | input | 1 | 1 = protected translation, 0 = legacy translation |
| seg_sel | input | 2 | Segment register used for this access |
| offset | input | 16 | Offset within the segment |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| ld_en | input | 1 | Write strobe for one cache entry |
| ld_idx | input | 2 | Entry written by the strobe |
| ld_segval | input | 16 | Paragraph number used in legacy mode |
| ld_base | input | 24 | Byte base used in protected mode |
| ld_limit | input | 16 | Segment limit |
| ld_code | input | 1 | 1 = code entry, 0 = data entry |
| ld_perm | input | 1 | Readable (code) or writable (data) |
| ld_down | input | 1 | Grow-down data entry |
| ld_null | input | 1 | Entry holds the null selector |
| lin_addr | output | 24 | Linear address |
| fault | output | 1 | Access rejected |
| fault_cause | output | 2 | 0 none, 1 limit, 2 access, 3 null |

## Verification
On every cycle, the assertions check a few things. Legacy mode never faults and never sets address bits above bit 19. The fault flag always matches the cause code. A freshly loaded null entry, or a freshly loaded code entry, is rejected on the next cycle with the right cause. The exact sums, including both wrap-arounds, the window boundaries on both sides of an expand-up and an expand-down limit, the permission rules and the fault priority are shown only by the bench's vectors. The bench's directed cases show the load timing, the isolation between entries and the reset contents.

// File: rtl/seg_agen_pkg.sv
package seg_agen_pkg;

    localparam int unsigned OFS_W   = 16;
    localparam int unsigned BASE_W  = 24;
    localparam int unsigned SEGV_W  = 16;
    localparam int unsigned PARA_SH = 4;
    localparam int unsigned LEG_W   = SEGV_W + PARA_SH;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_READ2 = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_LIMIT  = 2'd1,
        CAUSE_ACCESS = 2'd2,
        CAUSE_NULL   = 2'd3
    } fault_cause_e;

    typedef struct packed {
        logic [SEGV_W-1:0] segval;
        logic [BASE_W-1:0] base;
        logic [OFS_W-1:0]  limit;
        logic              is_code;
        logic              perm;
        logic              down;
        logic              is_null;
    } seg_entry_t;

    localparam seg_entry_t ENTRY_RESET = '{
        segval:  '0,
        base:    '0,
        limit:   '0,
        is_code: 1'b0,
        perm:    1'b0,
        down:    1'b0,
        is_null: 1'b1
    };

endpackage

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
    import seg_agen_pkg::*;
#(
    parameter int unsigned NSEG  = 4,
    localparam int unsigned IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  seg_entry_t       ld_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_entry_t       rd_entry
);

    typedef struct packed {
        seg_entry_t [NSEG-1:0] ent;
    } bank_t;

    bank_t bank_d;
    bank_t bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NSEG; i++) begin
            if (ld_en && (ld_idx == IDX_W'(i))) begin
                bank_d.ent[i] = ld_entry;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) begin
                bank_q.ent[i] <= ENTRY_RESET;
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_entry = bank_q.ent[rd_idx];

endmodule

// File: rtl/seg_legacy_xlate.sv
module seg_legacy_xlate
    import seg_agen_pkg::*;
(
    input  logic [SEGV_W-1:0] segval,
    input  logic [OFS_W-1:0]  offset,
    output logic [BASE_W-1:0] lin_addr
);

    logic [LEG_W-1:0] para_base;
    logic [LEG_W-1:0] sum;

    always_comb begin
        para_base = {segval, {PARA_SH{1'b0}}};
        sum       = para_base + LEG_W'(offset);
        lin_addr  = BASE_W'(sum);
    end

endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check
    import seg_agen_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic [OFS_W-1:0]  limit,
    input  logic              is_code,
    input  logic              perm,
    input  logic              down,
    input  logic              is_null,
    input  logic [OFS_W-1:0]  offset,
    input  acc_kind_e         acc,
    output logic [BASE_W-1:0] lin_addr,
    output fault_cause_e      cause
);

    logic acc_bad;
    logic lim_bad;
    logic grow_down;

    always_comb begin
        lin_addr = base + BASE_W'(offset);

        acc_bad = 1'b0;
        unique case (acc)
            ACC_WRITE: acc_bad = is_code | ~perm;
            ACC_FETCH: acc_bad = ~is_code;
            default:   acc_bad = is_code & ~perm;
        endcase

        grow_down = down & ~is_code;
        if (grow_down) begin
            lim_bad = (offset <= limit);
        end else begin
            lim_bad = (offset > limit);
        end

        if (is_null) begin
            cause = CAUSE_NULL;
        end else if (acc_bad) begin
            cause = CAUSE_ACCESS;
        end else if (lim_bad) begin
            cause = CAUSE_LIMIT;
        end else begin
            cause = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/seg_agen.sv
module seg_agen
    import seg_agen_pkg::*;
#(
    parameter int unsigned NSEG  = 4,
    localparam int unsigned IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_mode,
    input  logic [IDX_W-1:0]  seg_sel,
    input  logic [OFS_W-1:0]  offset,
    input  logic [1:0]        acc_kind,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [SEGV_W-1:0] ld_segval,
    input  logic [BASE_W-1:0] ld_base,
    input  logic [OFS_W-1:0]  ld_limit,
    input  logic              ld_code,
    input  logic              ld_perm,
    input  logic              ld_down,
    input  logic              ld_null,
    output logic [BASE_W-1:0] lin_addr,
    output logic              fault,
    output logic [1:0]        fault_cause
);

    seg_entry_t   new_entry;
    seg_entry_t   cur_entry;
    logic [BASE_W-1:0] leg_addr;
    logic [BASE_W-1:0] prot_addr;
    fault_cause_e prot_cause;

    always_comb begin
        new_entry = '{
            segval:  ld_segval,
            base:    ld_base,
            limit:   ld_limit,
            is_code: ld_code,
            perm:    ld_perm,
            down:    ld_down,
            is_null: ld_null
        };
    end

    seg_desc_bank #(.NSEG(NSEG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_idx   (ld_idx),
        .ld_entry (new_entry),
        .rd_idx   (seg_sel),
        .rd_entry (cur_entry)
    );

    seg_legacy_xlate u_legacy (
        .segval   (cur_entry.segval),
        .offset   (offset),
        .lin_addr (leg_addr)
    );

    seg_prot_check u_prot (
        .base     (cur_entry.base),
        .limit    (cur_entry.limit),
        .is_code  (cur_entry.is_code),
        .perm     (cur_entry.perm),
        .down     (cur_entry.down),
        .is_null  (cur_entry.is_null),
        .offset   (offset),
        .acc      (acc_kind_e'(acc_kind)),
        .lin_addr (prot_addr),
        .cause    (prot_cause)
    );

    always_comb begin
        if (prot_mode) begin
            lin_addr    = prot_addr;
            fault_cause = prot_cause;
        end else begin
            lin_addr    = leg_addr;
            fault_cause = CAUSE_NONE;
        end
        fault = (fault_cause != CAUSE_NONE);
    end

endmodule

// File: rtl/seg_agen_chk.sv
module seg_agen_chk
    import seg_agen_pkg::*;
#(
    parameter int unsigned NSEG  = 4,
    localparam int unsigned IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prot_mode,
    input logic [IDX_W-1:0]  seg_sel,
    input logic [1:0]        acc_kind,
    input logic              ld_en,
    input logic [IDX_W-1:0]  ld_idx,
    input logic              ld_code,
    input logic              ld_null,
    input logic [BASE_W-1:0] lin_addr,
    input logic              fault,
    input logic [1:0]        fault_cause
);

    a_r2_legacy_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_mode |-> (fault_cause == 2'd0));

    a_r1_legacy_width: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_mode |-> (lin_addr[BASE_W-1:LEG_W] == '0));

    a_r10_flag_matches_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fault == (fault_cause != 2'd0));

    a_r8_null_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_null) |=>
            ((prot_mode && seg_sel == $past(ld_idx)) -> (fault_cause == 2'd3)));

    a_r6_code_write_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_code && !ld_null) |=>
            ((prot_mode && seg_sel == $past(ld_idx) && acc_kind == 2'd1)
                -> (fault_cause == 2'd2)));

endmodule

bind seg_agen seg_agen_chk #(.NSEG(NSEG)) u_seg_agen_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prot_mode   (prot_mode),
    .seg_sel     (seg_sel),
    .acc_kind    (acc_kind),
    .ld_en       (ld_en),
    .ld_idx      (ld_idx),
    .ld_code     (ld_code),
    .ld_null     (ld_null),
    .lin_addr    (lin_addr),
    .fault       (fault),
    .fault_cause (fault_cause)
);

// File: tb/seg_agen_bench.sv
module seg_agen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_mode = 1'b0;
    logic [1:0]  seg_sel = '0;
    logic [15:0] offset = '0;
    logic [1:0]  acc_kind = '0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_idx = '0;
    logic [15:0] ld_segval = '0;
    logic [23:0] ld_base = '0;
    logic [15:0] ld_limit = '0;
    logic        ld_code = 1'b0;
    logic        ld_perm = 1'b0;
    logic        ld_down = 1'b0;
    logic        ld_null = 1'b0;
    logic [23:0] lin_addr;
    logic        fault;
    logic [1:0]  fault_cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_agen u_seg_agen (
        .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .seg_sel(seg_sel),
        .offset(offset), .acc_kind(acc_kind), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_segval(ld_segval), .ld_base(ld_base), .ld_limit(ld_limit),
        .ld_code(ld_code), .ld_perm(ld_perm), .ld_down(ld_down),
        .ld_null(ld_null), .lin_addr(lin_addr), .fault(fault),
        .fault_cause(fault_cause)
    );

    // {prot, sel, offset, acc, exp_addr, exp_cause}
    localparam int NV = 19;
    localparam logic [46:0] VEC [NV] = '{
        {1'b0, 2'd1, 16'h0235, 2'd0, 24'h03A255, 2'd0},  // R1
        {1'b0, 2'd0, 16'h1234, 2'd0, 24'h0F1234, 2'd0},  // R1
        {1'b0, 2'd3, 16'h0020, 2'd1, 24'h000010, 2'd0},  // R1 wrap, R2
        {1'b1, 2'd1, 16'h0235, 2'd0, 24'h03A255, 2'd0},  // R3
        {1'b1, 2'd1, 16'hFFFF, 2'd1, 24'h04A01F, 2'd0},  // R3
        {1'b1, 2'd0, 16'h0FFF, 2'd2, 24'h100FFF, 2'd0},  // R4 at limit
        {1'b1, 2'd0, 16'h1000, 2'd2, 24'h101000, 2'd1},  // R4 above
        {1'b1, 2'd0, 16'h0010, 2'd1, 24'h100010, 2'd2},  // R6 code write
        {1'b1, 2'd0, 16'h0010, 2'd0, 24'h100010, 2'd0},  // R7 readable code
        {1'b1, 2'd1, 16'h0000, 2'd2, 24'h03A020, 2'd2},  // R6 data fetch
        {1'b1, 2'd2, 16'h8000, 2'd0, 24'h208000, 2'd0},  // R5 limit+1
        {1'b1, 2'd2, 16'h7FFF, 2'd0, 24'h207FFF, 2'd1},  // R5 at limit
        {1'b1, 2'd2, 16'hFFFF, 2'd0, 24'h20FFFF, 2'd0},  // R5 top
        {1'b1, 2'd2, 16'h9000, 2'd1, 24'h209000, 2'd2},  // R7 read-only data
        {1'b1, 2'd2, 16'h0000, 2'd1, 24'h200000, 2'd2},  // R9 access over limit
        {1'b1, 2'd3, 16'h0010, 2'd0, 24'hFFFF10, 2'd2},  // R7 exec-only read
        {1'b1, 2'd3, 16'h0100, 2'd2, 24'h000000, 2'd1},  // R3 wrap, R4
        {1'b1, 2'd3, 16'h00F0, 2'd2, 24'hFFFFF0, 2'd0},  // R7 fetch ok
        {1'b1, 2'd1, 16'h0001, 2'd3, 24'h03A021, 2'd0}   // R6 kind 3 = read
    };

    task automatic check(input string req, input logic [23:0] exp_a,
                         input logic [1:0] exp_c);
        n_chk++;
        if (lin_addr !== exp_a || fault_cause !== exp_c || fault !== (exp_c != 2'd0)) begin
            n_bad++;
            $display("FAIL %s: addr=%h cause=%0d fault=%0b expected addr=%h cause=%0d",
                     req, lin_addr, fault_cause, fault, exp_a, exp_c);
        end
    endtask

    task automatic apply(input logic p, input logic [1:0] s, input logic [15:0] o,
                         input logic [1:0] a);
        @(negedge clk);
        prot_mode = p; seg_sel = s; offset = o; acc_kind = a;
        #1;
    endtask

    task automatic load(input logic [1:0] idx, input logic [15:0] sv,
                        input logic [23:0] b, input logic [15:0] lim,
                        input logic c, input logic pm, input logic dn,
                        input logic nl);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_segval = sv; ld_base = b; ld_limit = lim;
        ld_code = c; ld_perm = pm; ld_down = dn; ld_null = nl;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset contents
        apply(1'b1, 2'd0, 16'h0005, 2'd0);
        check("R12 null after reset", 24'h000005, 2'd3);
        apply(1'b0, 2'd2, 16'h1234, 2'd1);
        check("R12 legacy after reset", 24'h001234, 2'd0);

        load(2'd0, 16'hF000, 24'h100000, 16'h0FFF, 1'b1, 1'b1, 1'b0, 1'b0);
        load(2'd1, 16'h3A02, 24'h03A020, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0);
        load(2'd2, 16'h1234, 24'h200000, 16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b0);
        load(2'd3, 16'hFFFF, 24'hFFFF00, 16'h00FF, 1'b1, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][46], VEC[i][45:44], VEC[i][43:28], VEC[i][27:26]);
            check($sformatf("vector %0d (R1..R9 table)", i), VEC[i][25:2], VEC[i][1:0]);
        end

        // R11: load takes effect only after the edge
        @(negedge clk);
        prot_mode = 1'b1; seg_sel = 2'd2; offset = 16'hA000; acc_kind = 2'd0;
        ld_en = 1'b1; ld_idx = 2'd2; ld_segval = 16'h0; ld_base = 24'h500000;
        ld_limit = 16'hFFFF; ld_code = 1'b0; ld_perm = 1'b1; ld_down = 1'b0; ld_null = 1'b0;
        #1;
        check("R11 old entry before edge", 24'h20A000, 2'd0);
        @(negedge clk);
        ld_en = 1'b0;
        #1;
        check("R11 new entry after edge", 24'h50A000, 2'd0);
        apply(1'b1, 2'd1, 16'h0100, 2'd1);
        check("R11 other entry untouched", 24'h03A120, 2'd0);

        // R4: grow-down flag ignored on code entries
        load(2'd0, 16'hF000, 24'h100000, 16'h0FFF, 1'b1, 1'b1, 1'b1, 1'b0);
        apply(1'b1, 2'd0, 16'h0FFF, 2'd2);
        check("R4 down ignored on code (at limit)", 24'h100FFF, 2'd0);
        apply(1'b1, 2'd0, 16'h2000, 2'd2);
        check("R4 down ignored on code (above)", 24'h102000, 2'd1);

        // R8, R9: null outranks access and limit
        load(2'd3, 16'h0040, 24'h000100, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1);
        apply(1'b1, 2'd3, 16'h0800, 2'd1);
        check("R9 null over access and limit", 24'h000900, 2'd3);
        apply(1'b1, 2'd3, 16'h0000, 2'd2);
        check("R8 null at offset 0", 24'h000100, 2'd3);
        apply(1'b0, 2'd3, 16'h0008, 2'd1);
        check("R2 legacy ignores null flag", 24'h000408, 2'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule